// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

This block gathers five interrupt sources into sticky status bits and raises one interrupt line whenever any status bit is set and enabled. Each source has one enable bit in a mask register. A set bit enables the source. A clear bit keeps the source from reaching the interrupt line, but the source still records status. Software can force status bits for test by writing ones to the status register. It acknowledges status bits by writing ones to a separate clear register. Reading the status register also returns the live level of the core source in the top data bit.

The register port is a single-cycle strobe interface. A write strobe carries an address and data. A read strobe carries an address, and the selected value appears on the read data bus on the next cycle. The read data bus then holds that value until the next read. The core source and the nonce-refresh source are captured on their rising edges. The two hot-plug sources and the random-number error source set their bits in every cycle in which they are high. The reset input is asynchronous and active low. The surrounding reset tree is assumed to release it in step with the clock.

Top module: `irq_status_hub`

## Requirements
- R1: While reset is held and right after it is released, the mask and all status bits are zero, the interrupt output is low and the read data bus is zero.
- R2: A write to address 0 loads the mask from data bits 4:0. A read of address 0 returns the mask in bits 4:0, with every higher bit zero.
- R3: The interrupt output is high exactly when at least one status bit and its mask bit are both set. It follows register changes with no added cycle.
- R4: A write to address 1 sets each status bit 4:0 whose data bit is 1. Status bits are sticky. Writing 0 to a bit of address 1 leaves that bit unchanged.
- R5: A write to address 2 clears each status bit 4:0 whose data bit is 1. Writing 0 to a bit of address 2 leaves that bit unchanged.
- R6: If a hardware event and a clear reach the same status bit in the same cycle, the bit is set after that cycle.
- R7: Status bit 0 is set only in a cycle where the core input is high and was low in the previous cycle. The input is taken as low at reset. Once bit 0 is cleared, a core input that stays high does not set it again.
- R8: Status bit 3 (nonce refresh) is also set on a rising edge only. Status bits 1, 2 and 4 are set in every cycle their input is high.
- R9: A read of address 1 returns the live core input level in bit 31. A write of 1 to bit 31 of address 1 has no effect on any later read.
- R10: Read data is loaded one cycle after a read strobe and holds while no read strobe is given. Reads of address 2 and address 3 return zero.
- R11: The status bit order is 0 = core, 1 = hot-plug rise, 2 = hot-plug fall, 3 = nonce refresh, 4 = random-number error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_addr | input | 2 | Register address: 0 mask, 1 status/set, 2 clear, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| src_core | input | 1 | Core interrupt level (rising edge captured) |
| src_hpd_up | input | 1 | Hot-plug rise event |
| src_hpd_down | input | 1 | Hot-plug fall event |
| src_nonce | input | 1 | Nonce refresh level (rising edge captured) |
| src_rng_err | input | 1 | Random-number error event |
| irq | output | 1 | Aggregated interrupt output |

## Verification
The assertions assume that the source inputs and the register strobes are synchronous to the clock. They also assume that a write and a read never carry different addresses in the same cycle, because the block has a single address bus. The bench keeps to these assumptions by changing every input only on the falling clock edge. Each write or read it issues uses one address for one cycle. Its random phase varies source levels and strobe patterns freely within those rules.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int unsigned HUB_AW  = 2;
  localparam int unsigned HUB_NSRC = 5;

  typedef enum logic [HUB_AW-1:0] {
    REG_MASK = 2'd0,
    REG_STAT = 2'd1,
    REG_CLR  = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

  localparam int unsigned SRC_CORE  = 0;
  localparam int unsigned SRC_HPDUP = 1;
  localparam int unsigned SRC_HPDDN = 2;
  localparam int unsigned SRC_NONCE = 3;
  localparam int unsigned SRC_RNG   = 4;

endpackage

// File: rtl/irq_hub_evt.sv
module irq_hub_evt #(
  parameter int unsigned N        = 5,
  parameter logic [N-1:0] EDGE_SEL = 5'b01001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] evt_o
);

  for (genvar i = 0; i < N; i++) begin : g_src
    if (EDGE_SEL[i]) begin : g_edge
      logic prev_q;
      logic prev_d;

      always_comb begin
        prev_d = src_i[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
        end else begin
          prev_q <= prev_d;
        end
      end

      assign evt_o[i] = src_i[i] & ~prev_q;
    end else begin : g_level
      assign evt_o[i] = src_i[i];
    end
  end

endmodule

// File: rtl/irq_hub_bank.sv
module irq_hub_bank
  import irq_hub_pkg::*;
#(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     wr_sel,
  input  logic [N-1:0] wr_data,
  input  logic [N-1:0] evt,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] stat_q
);

  logic         mask_we;
  logic [N-1:0] mask_d;
  logic [N-1:0] set_v;
  logic [N-1:0] clr_v;
  logic [N-1:0] stat_d;
  logic         stat_en;

  always_comb begin
    mask_we = wr_en && (wr_sel == REG_MASK);
    mask_d  = mask_we ? wr_data : mask_q;
  end

  always_comb begin
    set_v   = (wr_en && (wr_sel == REG_STAT)) ? wr_data : '0;
    clr_v   = (wr_en && (wr_sel == REG_CLR))  ? wr_data : '0;
    // a hardware event in the same cycle overrides a clear
    stat_d  = (stat_q | set_v | evt) & ~(clr_v & ~evt);
    stat_en = |(set_v | clr_v | evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/irq_hub_rdmux.sv
module irq_hub_rdmux
  import irq_hub_pkg::*;
#(
  parameter int unsigned N        = 5,
  parameter int unsigned DW       = 32,
  parameter int unsigned LIVE_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  reg_sel_e      rd_sel,
  input  logic [N-1:0]  mask_q,
  input  logic [N-1:0]  stat_q,
  input  logic          live_core,
  output logic [DW-1:0] rdata_q
);

  logic [DW-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    unique case (rd_sel)
      REG_MASK: rdata_d[N-1:0] = mask_q;
      REG_STAT: begin
        rdata_d[N-1:0]  = stat_q;
        rdata_d[LIVE_BIT] = live_core;
      end
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned DW              = 32,
  parameter int unsigned LIVE_BIT        = 31,
  parameter logic [HUB_NSRC-1:0] EDGE_SEL = 5'b01001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [HUB_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              src_core,
  input  logic              src_hpd_up,
  input  logic              src_hpd_down,
  input  logic              src_nonce,
  input  logic              src_rng_err,
  output logic              irq
);

  localparam int unsigned NS = HUB_NSRC;

  logic [NS-1:0] src_vec;
  logic [NS-1:0] evt;
  logic [NS-1:0] mask_q;
  logic [NS-1:0] stat_q;
  reg_sel_e      sel;
  logic          unused_wdata;

  always_comb begin
    src_vec            = '0;
    src_vec[SRC_CORE]  = src_core;
    src_vec[SRC_HPDUP] = src_hpd_up;
    src_vec[SRC_HPDDN] = src_hpd_down;
    src_vec[SRC_NONCE] = src_nonce;
    src_vec[SRC_RNG]   = src_rng_err;
    sel                = reg_sel_e'(reg_addr);
  end

  assign unused_wdata = ^reg_wdata[DW-1:NS];

  irq_hub_evt #(
    .N        (NS),
    .EDGE_SEL (EDGE_SEL)
  ) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_vec),
    .evt_o (evt)
  );

  irq_hub_bank #(
    .N (NS)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_sel  (sel),
    .wr_data (reg_wdata[NS-1:0]),
    .evt     (evt),
    .mask_q  (mask_q),
    .stat_q  (stat_q)
  );

  irq_hub_rdmux #(
    .N        (NS),
    .DW       (DW),
    .LIVE_BIT (LIVE_BIT)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (reg_rd),
    .rd_sel    (sel),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .live_core (src_core),
    .rdata_q   (reg_rdata)
  );

  assign irq = |(stat_q & mask_q);

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int unsigned N        = 5,
  parameter int unsigned DW       = 32,
  parameter int unsigned LIVE_BIT = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [HUB_AW-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     reg_rdata,
  input logic              src_core,
  input logic [N-1:0]      evt,
  input logic [N-1:0]      stat,
  input logic [N-1:0]      mask,
  input logic              irq
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  // R3: nothing enabled means no interrupt
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  // R4: set-write makes every written bit visible next cycle
  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reg_wr && reg_addr == REG_STAT)
    |=> ((stat & $past(reg_wdata[N-1:0])) == $past(reg_wdata[N-1:0])));

  // R5: clearing all bits with no event leaves status empty
  a_r5_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_CLR && (&reg_wdata[N-1:0]) && evt == '0)
    |=> (stat == '0));

  for (genvar i = 0; i < N; i++) begin : g_bit
    // R4: a set bit stays set unless a clear names it
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && stat[i] && !(reg_wr && reg_addr == REG_CLR && reg_wdata[i]))
      |=> stat[i]);
    // R6: an event always leaves its bit set
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> stat[i]);
  end

  // R7: a rising core input records bit 0
  a_r7_core_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(src_core)) |=> stat[0]);

  // R9: live core level on status reads
  a_r9_live_core: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reg_rd && reg_addr == REG_STAT)
    |=> (reg_rdata[LIVE_BIT] == $past(src_core)));

  // R10: read data holds between reads
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !reg_rd) |=> $stable(reg_rdata));

endmodule

bind irq_status_hub irq_hub_chk #(
  .N        (irq_hub_pkg::HUB_NSRC),
  .DW       (DW),
  .LIVE_BIT (LIVE_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .src_core  (src_core),
  .evt       (evt),
  .stat      (stat_q),
  .mask      (mask_q),
  .irq       (irq)
);

// File: tb/tb_irq_status_hub.sv
module tb_irq_status_hub;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_rd;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        src_core;
  logic        src_hpd_up;
  logic        src_hpd_down;
  logic        src_nonce;
  logic        src_rng_err;
  logic        irq;

  int total = 0;
  int bad   = 0;

  irq_status_hub dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .src_core     (src_core),
    .src_hpd_up   (src_hpd_up),
    .src_hpd_down (src_hpd_down),
    .src_nonce    (src_nonce),
    .src_rng_err  (src_rng_err),
    .irq          (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference, updated on each rising edge
  logic [31:0] m_mask, m_stat, m_rdata;
  logic        m_core_prev, m_nonce_prev, m_irq;

  always @(posedge clk) begin
    logic [31:0] ev;
    if (!rst_n) begin
      m_mask = 0; m_stat = 0; m_rdata = 0;
      m_core_prev = 0; m_nonce_prev = 0;
    end else begin
      ev = 0;
      ev[0] = src_core && !m_core_prev;
      ev[1] = src_hpd_up;
      ev[2] = src_hpd_down;
      ev[3] = src_nonce && !m_nonce_prev;
      ev[4] = src_rng_err;
      if (reg_rd) begin
        if (reg_addr == 0)      m_rdata = m_mask;
        else if (reg_addr == 1) m_rdata = m_stat | (32'(src_core) << 31);
        else                    m_rdata = 0;
      end
      if (reg_wr && reg_addr == 0) m_mask = reg_wdata & 32'h1F;
      if (reg_wr && reg_addr == 1) m_stat = m_stat | (reg_wdata & 32'h1F);
      if (reg_wr && reg_addr == 2) m_stat = m_stat & ~(reg_wdata & 32'h1F);
      m_stat = m_stat | ev;
      m_core_prev = src_core;
      m_nonce_prev = src_nonce;
    end
    m_irq = (m_stat & m_mask) != 0;
  end

  task automatic check_eq(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  // advance one cycle, then compare with the model away from the edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      check_eq({31'd0, irq}, {31'd0, m_irq}, "R3 model irq");
      check_eq(reg_rdata, m_rdata, "R10 model rdata");
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    reg_rd = 1; reg_addr = a;
    tick();
    reg_rd = 0;
    check_eq(reg_rdata, exp, req);
  endtask

  task automatic pulse_src(input int which);
    case (which)
      0: src_core = 1;
      1: src_hpd_up = 1;
      2: src_hpd_down = 1;
      3: src_nonce = 1;
      default: src_rng_err = 1;
    endcase
    tick();
    src_core = 0; src_hpd_up = 0; src_hpd_down = 0; src_nonce = 0; src_rng_err = 0;
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    src_core = 0; src_hpd_up = 0; src_hpd_down = 0; src_nonce = 0; src_rng_err = 0;
    repeat (3) @(negedge clk);
    check_eq({31'd0, irq}, 32'd0, "R1 irq in reset");
    check_eq(reg_rdata, 32'd0, "R1 rdata in reset");
    rst_n = 1;
    tick();
    check_eq({31'd0, irq}, 32'd0, "R1 irq after reset");
    rd_chk(0, 32'h0, "R1 mask after reset");
    rd_chk(1, 32'h0, "R1 status after reset");

    // R2 mask width
    wr(0, 32'hFFFF_FFFF);
    rd_chk(0, 32'h1F, "R2 mask readback");
    wr(0, 32'h0);
    rd_chk(0, 32'h0, "R2 mask cleared");

    // R4 set and zero-write
    wr(1, 32'h5);
    rd_chk(1, 32'h5, "R4 set bits");
    check_eq({31'd0, irq}, 32'd0, "R3 masked off");
    wr(1, 32'h0);
    rd_chk(1, 32'h5, "R4 zero write no effect");

    // R3 mask gating
    wr(0, 32'h4);
    check_eq({31'd0, irq}, 32'd1, "R3 enabled bit raises irq");
    wr(0, 32'h2);
    check_eq({31'd0, irq}, 32'd0, "R3 disabled bit drops irq");

    // R5 clear
    wr(2, 32'h0);
    rd_chk(1, 32'h5, "R5 zero clear no effect");
    wr(2, 32'h1);
    rd_chk(1, 32'h4, "R5 single clear");
    rd_chk(2, 32'h0, "R10 clear reg reads zero");
    rd_chk(3, 32'h0, "R10 unused addr reads zero");
    wr(2, 32'h1F);
    rd_chk(1, 32'h0, "R5 full clear");

    // R11 bit order
    wr(0, 32'h1F);
    for (int i = 0; i < 5; i++) begin
      pulse_src(i);
      check_eq({31'd0, irq}, 32'd1, "R11 irq on source");
      rd_chk(1, 32'(1) << i, "R11 bit position");
      wr(2, 32'h1F);
    end

    // R7 core edge and R9 live level
    src_core = 1;
    tick();
    rd_chk(1, 32'h8000_0001, "R7 R9 core edge and live level");
    wr(2, 32'h1);
    tick();
    rd_chk(1, 32'h8000_0000, "R7 held core does not re-set");
    src_core = 0;
    tick();
    rd_chk(1, 32'h0, "R9 live level low");

    // R8 nonce edge versus level sources
    src_nonce = 1; src_hpd_down = 1;
    tick();
    wr(2, 32'h0C);
    tick();
    rd_chk(1, 32'h04, "R8 nonce edge only, hpd fall level");
    src_nonce = 0; src_hpd_down = 0;
    wr(2, 32'h1F);

    // R6 event wins over clear
    src_rng_err = 1; reg_wr = 1; reg_addr = 2; reg_wdata = 32'h10;
    tick();
    reg_wr = 0; src_rng_err = 0;
    rd_chk(1, 32'h10, "R6 event beats clear");
    wr(2, 32'h1F);

    // R9 write to bit 31 ignored
    wr(1, 32'h8000_0000);
    rd_chk(1, 32'h0, "R9 bit31 write ignored");

    // R10 hold between reads
    rd_chk(0, 32'h1F, "R10 read mask");
    held = reg_rdata;
    wr(1, 32'h3);
    tick();
    check_eq(reg_rdata, held, "R10 rdata holds");
    wr(2, 32'h1F);

    // random phase against the model
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = $urandom % 8;
      reg_wr = (r == 0) || (r == 1);
      reg_rd = (r == 2) || (r == 3);
      reg_addr = 2'($urandom % 4);
      reg_wdata = $urandom;
      src_core = ($urandom % 4) == 0;
      src_hpd_up = ($urandom % 8) == 0;
      src_hpd_down = ($urandom % 8) == 0;
      src_nonce = ($urandom % 3) == 0;
      src_rng_err = ($urandom % 16) == 0;
      tick();
    end
    reg_wr = 0; reg_rd = 0;
    src_core = 0; src_hpd_up = 0; src_hpd_down = 0; src_nonce = 0; src_rng_err = 0;
    tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule